// File: doc/BRIEF.md
# DMA Burst Register Access Window

This block sits in a peripheral's register file and lets a DMA engine reload a run of neighbouring registers through one fixed bus address. Software first sets a start offset and a transfer count in a burst control register. Each peripheral event then starts a burst. The block raises a DMA request once per transfer. Every access to the window address is steered to the register at start offset plus a running index.

The bank holds `NUM_REGS` target registers at word addresses 0 upward. Offset 0 is the first control register of the peripheral, offset 1 is the second control register, and offset 2 is the slave-mode control register. Data carried through the window really overwrites these registers, and that includes the control registers. Reads through the window return their contents. The burst control register and the window sit at their own addresses, `CTRL_ADDR` and `WIN_ADDR`. The DMA controller acknowledges each transfer in the same cycle it makes its window access.

Top module: `dma_burst_window`

## Requirements
- R1: After reset, every target register and the burst control register read as zero and `dma_req` is low.
- R2: Bus addresses below `NUM_REGS` read and write the target register of that number directly. The burst control register holds the start offset in bits 4:0 and the encoded length in bits 12:8, and it reads back in that layout. Addresses that map to nothing read as zero.
- R3: A `periph_evt` pulse resets the burst index to 0 and sets `dma_req` high on the following clock edge.
- R4: An access to `WIN_ADDR` reads or writes the target register at start offset plus the current index, and a write really replaces that register's value.
- R5: A cycle with both `dma_req` and `dma_ack` high advances the index by one and drops `dma_req` at that edge. If transfers remain, `dma_req` goes high again at the next edge.
- R6: With encoded length k, a burst makes exactly k+1 transfers. After that, `dma_req` stays low until the next event, and the index never exceeds the transfer count.
- R7: A write to the burst control register clamps the length field to NUM_REGS-1-offset when the offset is inside the bank, and to 0 when it is not. The clamped value is what reads back.
- R8: A window access that resolves to an offset at or above `NUM_REGS` reads as zero and leaves every register unchanged.
- R9: A bus write to the burst control register aborts any burst in progress. `dma_req` is low after that edge and the index returns to 0. This write takes priority over an event in the same cycle.
- R10: Without an acknowledge, a raised `dma_req` stays high from cycle to cycle.
- R11: An event that arrives during a burst restarts it from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| periph_evt | input | 1 | Peripheral event pulse that starts a burst |
| dma_req | output | 1 | Level DMA request, one per transfer |
| dma_ack | input | 1 | DMA acknowledge, given with the window access |

## Verification
The bench uses the default build: eight target registers, 16-bit data, a 5-bit address with the control register at 8 and the window at 9. Because the 5-bit start offset can point well past eight registers, both kinds of clamping can be reached: a long length cut down to fit the bank, and offsets outside the bank that fall back to a single transfer. Unimplemented window targets can be reached with small stimulus too, so random offsets over the whole field reach all of these cases alongside directed bursts, aborts and restarts.

// File: rtl/dbw_pkg.sv
package dbw_pkg;

    // Start offset and length field widths, fixed by the control layout
    localparam int unsigned OFS_W   = 5;
    localparam int unsigned LEN_W   = 5;
    // Bit position of the length field inside the control word
    localparam int unsigned LEN_LSB = 8;
    // Counter width: holds any transfer count up to 2**LEN_W
    localparam int unsigned CNT_W   = OFS_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [OFS_W-1:0] base;
    } ctrl_t;

    typedef struct packed {
        logic             active;
        logic             req;
        logic [CNT_W-1:0] idx;
    } seq_t;

endpackage

// File: rtl/dbw_ctrl_reg.sv
module dbw_ctrl_reg
    import dbw_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_base,
    input  logic [LEN_W-1:0] wr_len,
    output ctrl_t            ctrl
);

    localparam logic [CNT_W-1:0] NREG_C = CNT_W'(NUM_REGS);

    ctrl_t            ctrl_d, ctrl_q;
    logic [CNT_W-1:0] base_ext;
    logic [CNT_W-1:0] room;
    logic [CNT_W-1:0] len_ext;

    always_comb begin
        ctrl_d   = ctrl_q;
        base_ext = {1'b0, wr_base};
        len_ext  = {1'b0, wr_len};
        room     = '0;
        if (base_ext < NREG_C) begin
            room = NREG_C - base_ext - CNT_W'(1);
        end
        if (wr_en) begin
            ctrl_d.base = wr_base;
            if (base_ext >= NREG_C) begin
                ctrl_d.len = '0;
            end else if (len_ext > room) begin
                ctrl_d.len = room[LEN_W-1:0];
            end else begin
                ctrl_d.len = wr_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/dbw_sequencer.sv
module dbw_sequencer
    import dbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             evt,
    input  logic             ack,
    input  logic [CNT_W-1:0] count,
    output logic             req,
    output logic [CNT_W-1:0] idx
);

    seq_t             st_d, st_q;
    logic [CNT_W-1:0] idx_inc;

    always_comb begin
        st_d    = st_q;
        idx_inc = st_q.idx + CNT_W'(1);
        if (abort) begin
            st_d = '0;
        end else if (evt) begin
            st_d.active = 1'b1;
            st_d.req    = 1'b1;
            st_d.idx    = '0;
        end else if (st_q.active) begin
            if (st_q.req && ack) begin
                st_d.idx = idx_inc;
                st_d.req = 1'b0;
                if (idx_inc >= count) begin
                    st_d.active = 1'b0;
                end
            end else if (!st_q.req) begin
                st_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;
    assign idx = st_q.idx;

endmodule

// File: rtl/dbw_reg_bank.sv
module dbw_reg_bank
    import dbw_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [CNT_W-1:0] NREG_C = CNT_W'(NUM_REGS);

    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic              hit;

    assign hit = (ofs < NREG_C);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [DATA_W-1:0] val_d;
        logic              sel;

        assign sel = wr_en && hit && (ofs == CNT_W'(i));

        always_comb begin
            val_d = regs_q[i];
            if (sel) begin
                val_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= val_d;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int j = 0; j < NUM_REGS; j++) begin
            if (ofs == CNT_W'(j)) begin
                rdata = regs_q[j];
            end
        end
    end

endmodule

// File: rtl/dma_burst_window.sv
module dma_burst_window
    import dbw_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned CTRL_ADDR = 8,
    parameter int unsigned WIN_ADDR  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              periph_evt,
    output logic              dma_req,
    input  logic              dma_ack
);

    localparam int unsigned CTRL_BITS = LEN_LSB + LEN_W;

    ctrl_t            ctrl;
    logic             is_direct;
    logic             is_ctrl;
    logic             is_win;
    logic             ctrl_wr;
    logic             bank_wr;
    logic [CNT_W-1:0] burst_cnt;
    logic [CNT_W-1:0] seq_idx;
    logic [CNT_W-1:0] tgt_ofs;
    logic [CNT_W-1:0] eff_ofs;
    logic [DATA_W-1:0] bank_rdata;
    logic [CTRL_BITS-1:0] ctrl_word;

    assign is_direct = (bus_addr < ADDR_W'(NUM_REGS));
    assign is_ctrl   = (bus_addr == ADDR_W'(CTRL_ADDR));
    assign is_win    = (bus_addr == ADDR_W'(WIN_ADDR));
    assign ctrl_wr   = bus_sel && bus_we && is_ctrl;
    assign bank_wr   = bus_sel && bus_we && (is_direct || is_win);

    assign burst_cnt = {1'b0, ctrl.len} + CNT_W'(1);
    assign tgt_ofs   = {1'b0, ctrl.base} + seq_idx;
    assign eff_ofs   = is_direct ? CNT_W'(bus_addr) : tgt_ofs;

    dbw_ctrl_reg #(
        .NUM_REGS (NUM_REGS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_base (bus_wdata[OFS_W-1:0]),
        .wr_len  (bus_wdata[LEN_LSB +: LEN_W]),
        .ctrl    (ctrl)
    );

    dbw_sequencer u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (ctrl_wr),
        .evt   (periph_evt),
        .ack   (dma_ack),
        .count (burst_cnt),
        .req   (dma_req),
        .idx   (seq_idx)
    );

    dbw_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_wr),
        .ofs   (eff_ofs),
        .wdata (bus_wdata),
        .rdata (bank_rdata)
    );

    always_comb begin
        ctrl_word = '0;
        ctrl_word[OFS_W-1:0]          = ctrl.base;
        ctrl_word[LEN_LSB +: LEN_W]   = ctrl.len;
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (is_ctrl) begin
                bus_rdata = DATA_W'(ctrl_word);
            end else if (is_direct || is_win) begin
                bus_rdata = bank_rdata;
            end
        end
    end

endmodule

// File: rtl/dbw_window_chk.sv
module dbw_window_chk
    import dbw_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned WIN_ADDR = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              periph_evt,
    input logic              dma_req,
    input logic              dma_ack,
    input logic              ctrl_wr,
    input logic [CNT_W-1:0]  idx,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  tgt
);

    // R3
    evt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_evt && !ctrl_wr) |=> dma_req);

    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && !ctrl_wr && !periph_evt) |=> !dma_req);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && !ctrl_wr) |=> dma_req);

    // R9
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (!dma_req && idx == '0));

    // R8
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == ADDR_W'(WIN_ADDR) && tgt >= CNT_W'(NUM_REGS))
        |-> bus_rdata == '0);

    // R6
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= count);

endmodule

bind dma_burst_window dbw_window_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .WIN_ADDR (WIN_ADDR)
) u_window_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .periph_evt (periph_evt),
    .dma_req    (dma_req),
    .dma_ack    (dma_ack),
    .ctrl_wr    (ctrl_wr),
    .idx        (seq_idx),
    .count      (burst_cnt),
    .tgt        (tgt_ofs)
);

// File: tb/tb_dma_burst_window.sv
module tb_dma_burst_window;

    localparam int CLK_P = 10;
    localparam int NREG  = 8;
    localparam int CTRLA = 8;
    localparam int WINA  = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        periph_evt = 1'b0;
    logic        dma_req;
    logic        dma_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [15:0] mregs [NREG];
    int  mbase = 0;
    int  mlen = 0;
    int  midx = 0;
    bit  mactive = 0;
    bit  mreq = 0;

    always #(CLK_P/2) clk = ~clk;

    dma_burst_window dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .periph_evt (periph_evt),
        .dma_req    (dma_req),
        .dma_ack    (dma_ack)
    );

    function automatic int clamp_len(int b, int k);
        int room;
        if (b >= NREG) return 0;
        room = NREG - 1 - b;
        return (k > room) ? room : k;
    endfunction

    function automatic logic [15:0] exp_rd(int a);
        int t;
        if (a < NREG) return mregs[a];
        if (a == CTRLA) return 16'((mlen << 8) | mbase);
        if (a == WINA) begin
            t = mbase + midx;
            return (t < NREG) ? mregs[t] : 16'h0;
        end
        return 16'h0;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic seq_edge(bit abort, bit evt, bit ack);
        if (abort) begin
            mactive = 0; mreq = 0; midx = 0;
        end else if (evt) begin
            mactive = 1; mreq = 1; midx = 0;
        end else if (mactive) begin
            if (mreq && ack) begin
                midx++;
                mreq = 0;
                if (midx >= mlen + 1) mactive = 0;
            end else if (!mreq) begin
                mreq = 1;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cpu_wr(int a, logic [15:0] d);
        int t;
        bus_sel = 1; bus_we = 1; bus_addr = 5'(a); bus_wdata = d;
        tick();
        bus_sel = 0; bus_we = 0;
        if (a < NREG) begin
            mregs[a] = d;
            seq_edge(0, 0, 0);
        end else if (a == CTRLA) begin
            mbase = int'(d[4:0]);
            mlen  = clamp_len(mbase, int'(d[12:8]));
            seq_edge(1, 0, 0);
        end else begin
            if (a == WINA) begin
                t = mbase + midx;
                if (t < NREG) mregs[t] = d;
            end
            seq_edge(0, 0, 0);
        end
    endtask

    task automatic cpu_rd(int a, string tag);
        bus_sel = 1; bus_we = 0; bus_addr = 5'(a);
        #1;
        chk(tag, bus_rdata, exp_rd(a));
        tick();
        seq_edge(0, 0, 0);
        bus_sel = 0;
        chk({tag, " req"}, {15'h0, dma_req}, {15'h0, mreq});
    endtask

    task automatic fire(string tag);
        periph_evt = 1;
        tick();
        periph_evt = 0;
        seq_edge(0, 1, 0);
        chk(tag, {15'h0, dma_req}, 16'h1);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            tick();
            seq_edge(0, 0, 0);
            chk(tag, {15'h0, dma_req}, {15'h0, mreq});
        end
    endtask

    task automatic dma_step(bit wr, logic [15:0] d);
        int t;
        bus_sel = 1; bus_we = wr; bus_addr = 5'(WINA); bus_wdata = d; dma_ack = 1;
        t = mbase + midx;
        #1;
        if (!wr) chk((t < NREG) ? "R4 window read" : "R8 unimpl read", bus_rdata, exp_rd(WINA));
        tick();
        bus_sel = 0; bus_we = 0; dma_ack = 0;
        if (wr && t < NREG) mregs[t] = d;
        seq_edge(0, 0, 1);
        chk("R5 req drops on ack", {15'h0, dma_req}, {15'h0, mreq});
        tick();
        seq_edge(0, 0, 0);
        chk("R5 R6 req after gap", {15'h0, dma_req}, {15'h0, mreq});
    endtask

    task automatic run_burst(bit wr);
        fire("R3 event raises req");
        while (mactive) begin
            if (!mreq) idle(1, "R5 re-raise");
            else begin
                if ($urandom_range(0, 2) == 0) idle(2, "R10 req held");
                dma_step(wr, 16'($urandom));
            end
        end
        idle(3, "R6 req stays low after burst");
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < NREG; i++) cpu_rd(i, tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NREG; i++) mregs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 req low", {15'h0, dma_req}, 16'h0);
        read_all("R1 reg zero");
        cpu_rd(CTRLA, "R1 ctrl zero");

        // R2 direct access and control layout
        for (int i = 0; i < NREG; i++) cpu_wr(i, 16'h1000 + 16'(i));
        read_all("R2 direct readback");
        cpu_wr(CTRLA, 16'h0600);
        cpu_rd(CTRLA, "R2 ctrl layout");
        chk("R2 ctrl literal", exp_rd(CTRLA), 16'h0600);
        cpu_rd(20, "R2 unmapped addr");

        // R4 seven-transfer write burst from offset 0, control regs overwritten
        fire("R3 event raises req");
        for (int k = 0; k < 7; k++) dma_step(1, 16'hA000 + 16'(k));
        idle(3, "R6 burst of seven ends");
        read_all("R4 window writes landed");
        chk("R4 reg0 overwritten", mregs[0], 16'hA000);

        // R4 read burst
        cpu_wr(CTRLA, 16'h0302);
        run_burst(0);

        // R7 clamp
        cpu_wr(CTRLA, 16'h1F05);
        cpu_rd(CTRLA, "R7 clamped length");
        chk("R7 clamp literal", exp_rd(CTRLA), 16'h0205);
        run_burst(1);
        read_all("R7 clamped burst");

        // R8 unimplemented offset
        cpu_wr(CTRLA, 16'h0914);
        cpu_rd(CTRLA, "R7 out of bank length");
        fire("R3 event raises req");
        dma_step(1, 16'hDEAD);
        read_all("R8 write ignored");
        fire("R3 event raises req");
        dma_step(0, 16'h0);
        cpu_rd(WINA, "R8 window zero");

        // R9 abort mid-burst
        cpu_wr(CTRLA, 16'h0501);
        fire("R3 event raises req");
        dma_step(1, 16'hB001);
        dma_step(1, 16'hB002);
        cpu_wr(CTRLA, 16'h0501);
        chk("R9 abort drops req", {15'h0, dma_req}, 16'h0);
        idle(3, "R9 stays idle");
        cpu_rd(WINA, "R9 index back to 0");

        // R9 control write beats simultaneous event
        fire("R3 event raises req");
        bus_sel = 1; bus_we = 1; bus_addr = 5'(CTRLA); bus_wdata = 16'h0300;
        periph_evt = 1;
        tick();
        bus_sel = 0; bus_we = 0; periph_evt = 0;
        mbase = 0; mlen = 3;
        seq_edge(1, 1, 0);
        chk("R9 write wins over event", {15'h0, dma_req}, 16'h0);

        // R11 restart mid-burst
        cpu_wr(CTRLA, 16'h0303);
        fire("R3 event raises req");
        dma_step(1, 16'hC001);
        dma_step(1, 16'hC002);
        fire("R11 restart raises req");
        cpu_rd(WINA, "R11 index restarted");
        while (mactive) begin
            if (mreq) dma_step(1, 16'hC100 + 16'(midx));
            else idle(1, "R5 re-raise");
        end
        read_all("R11 restarted burst data");

        // R10 long hold
        fire("R3 event raises req");
        idle(6, "R10 req held without ack");
        while (mactive) begin
            if (mreq) dma_step(0, 16'h0);
            else idle(1, "R5 re-raise");
        end

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0: cpu_wr($urandom_range(0, NREG - 1), 16'($urandom));
                1: cpu_rd($urandom_range(0, 15), "R2 R4 random read");
                2: begin
                    int b;
                    b = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : $urandom_range(0, 9);
                    cpu_wr(CTRLA, 16'(($urandom_range(0, 31) << 8) | b));
                    cpu_rd(CTRLA, "R7 random clamp");
                end
                3: fire("R3 R11 random event");
                4, 5: begin
                    if (mreq) dma_step(1'($urandom_range(0, 1)), 16'($urandom));
                    else idle(1, "R6 R10 random idle");
                end
                default: cpu_wr(WINA, 16'($urandom));
            endcase
        end
        read_all("R4 final bank");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule